// File: doc/BRIEF.md
# Multi-Lane Block Striping Transmitter

This block sits after the encoder and scrambler of a wide serial link. It takes a stream of 66-bit coded blocks over a valid/ready handshake. It deals the blocks one at a time, in a fixed rotating order, across a set of virtual lanes. The lane count is a parameter: 20 for the high-rate configuration and 4 for the low-rate one. Each lane has its own 66-bit output register and its own valid bit. The serializer or bit multiplexer downstream takes these per-lane streams.

Each lane also carries a periodic marker block that holds its lane number, so a receiver can tell lanes apart and remove the skew between them. All lanes send their markers in the same output cycle. The markers use link bandwidth. To pay for them, the block withholds `in_ready` for one cycle per lane, and it raises `idle_drop` in each of those cycles. Each `idle_drop` cycle tells the upstream source to delete one inter-packet idle block. Data is therefore never held back for good.

Top module: `lane_stripe_tx`

## Requirements
- R1: Accepted blocks go to lanes in strict rotation: lane 0 first, then lane 1, and so on, wrapping from lane `LANES-1` back to lane 0. The rotation restarts at lane 0 after every marker group.
- R2: A block accepted on a clock edge (`in_valid` and `in_ready` both high) appears unchanged on `lane_data[k*66 +: 66]` of its lane `k` after that edge. On the same edge only that lane's bit of `lane_valid` rises.
- R3: After exactly `LANES*PERIOD` accepted data blocks (`PERIOD` per lane), a marker group starts. In the first cycle of the group every lane presents its marker at once, with all `lane_valid` bits high.
- R4: The marker of lane `n` has bits [65:64] = 2'b10, bits [7:0] = 8'hA5, bits [15:8] = n, bits [23:16] = the bitwise complement of n, and bits [63:24] = 0.
- R5: A marker group lasts `LANES` cycles. In each of them `in_ready` is low and `idle_drop` is high. Outside marker groups `idle_drop` is low and `in_ready` is high.
- R6: Synchronous reset clears all `lane_valid` bits. The first marker group starts in the first cycle after reset is released, so the first markers are visible after the first clock edge with reset low.
- R7: A cycle with `in_valid` low emits no data and does not move the rotation.
- R8: When no block is accepted and no marker group begins, every `lane_valid` bit is low after the next edge.
- R9: The design works with `LANES` = 20, where the markers carry lane numbers 0 to 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream block is present |
| in_data | input | 66 | Encoded block from the aggregate path |
| in_ready | output | 1 | Block is taken on this edge if `in_valid` is high |
| lane_data | output | LANES*66 | Per-lane output words, lane k in bits [k*66 +: 66] |
| lane_valid | output | LANES | Per-lane word valid |
| idle_drop | output | 1 | Upstream must delete one idle block, once per high cycle |

## Verification
A wrong rotation pointer shows on the next accepted block: that block comes out on the wrong lane, and the scoreboard catches it one cycle later. A wrong block counter moves the marker group early or late. That error shows up when markers arrive while data is expected, or when data arrives while markers are expected, at the first period boundary. A phase counter that stops at the wrong value changes the number of cycles in which `idle_drop` is high. Wrong marker contents are compared lane by lane on the very first group after reset.

// File: rtl/lane_stripe_pkg.sv
package lane_stripe_pkg;

    localparam int BLK_W = 66;

    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic {
        PH_MARK = 1'b0,
        PH_DATA = 1'b1
    } phase_t;

    localparam logic [1:0] SYNC_CTRL = 2'b10;
    localparam logic [7:0] MARK_TYPE = 8'hA5;

    // Lane marker: control sync, fixed type, lane id and its complement.
    function automatic blk_t make_marker(input logic [7:0] id);
        return {SYNC_CTRL, 40'h0, ~id, id, MARK_TYPE};
    endfunction

    function automatic int ptr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/stripe_rr_ptr.sv
module stripe_rr_ptr
    import lane_stripe_pkg::*;
#(
    parameter int LANES = 20,
    localparam int PW = ptr_width(LANES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    input  logic          clear_i,
    output logic [PW-1:0] ptr_o
);

    localparam logic [PW-1:0] LAST = PW'(LANES - 1);

    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (clear_i) begin
            ptr_q <= '0;
        end else if (adv_i) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr_o = ptr_q;

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= LAST); // R1
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !clear_i) |=> $stable(ptr_q)); // R7

endmodule

// File: rtl/stripe_mark_timer.sv
module stripe_mark_timer
    import lane_stripe_pkg::*;
#(
    parameter int LANES  = 20,
    parameter int PERIOD = 16384,
    localparam int TOTAL = LANES * PERIOD,
    localparam int BW    = ptr_width(TOTAL),
    localparam int MW    = ptr_width(LANES)
) (
    input  logic clk,
    input  logic rst,
    input  logic accept_i,
    output logic data_phase_o,
    output logic mark_fire_o,
    output logic drop_o
);

    localparam logic [BW-1:0] BLK_LAST  = BW'(TOTAL - 1);
    localparam logic [MW-1:0] MARK_LAST = MW'(LANES - 1);

    phase_t        phase_q;
    logic [BW-1:0] bcnt_q;
    logic [MW-1:0] mcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_MARK;
            bcnt_q  <= '0;
            mcnt_q  <= '0;
        end else begin
            case (phase_q)
                PH_MARK: begin
                    if (mcnt_q == MARK_LAST) begin
                        phase_q <= PH_DATA;
                        mcnt_q  <= '0;
                    end else begin
                        mcnt_q <= mcnt_q + 1'b1;
                    end
                    bcnt_q <= '0;
                end
                default: begin
                    if (accept_i) begin
                        if (bcnt_q == BLK_LAST) begin
                            phase_q <= PH_MARK;
                            bcnt_q  <= '0;
                        end else begin
                            bcnt_q <= bcnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign data_phase_o = (phase_q == PH_DATA);
    assign mark_fire_o  = (phase_q == PH_MARK) && (mcnt_q == '0);
    assign drop_o       = (phase_q == PH_MARK);

    AST_BCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        bcnt_q <= BLK_LAST); // R3
    AST_NO_ACCEPT_IN_MARK: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_MARK) |-> !accept_i); // R5
    AST_MCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        mcnt_q <= MARK_LAST); // R5

endmodule

// File: rtl/stripe_lane_regs.sv
module stripe_lane_regs
    import lane_stripe_pkg::*;
#(
    parameter int LANES = 20,
    localparam int PW = ptr_width(LANES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mark_fire_i,
    input  logic                   accept_i,
    input  logic [PW-1:0]          ptr_i,
    input  blk_t                   blk_i,
    output logic [LANES*BLK_W-1:0] data_o,
    output logic [LANES-1:0]       valid_o
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        blk_t word_q;
        logic vld_q;
        logic hit;

        assign hit = accept_i && (ptr_i == PW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
                vld_q  <= 1'b0;
            end else if (mark_fire_i) begin
                word_q <= make_marker(8'(i));
                vld_q  <= 1'b1;
            end else if (hit) begin
                word_q <= blk_i;
                vld_q  <= 1'b1;
            end else begin
                vld_q  <= 1'b0;
            end
        end

        assign data_o[i*BLK_W +: BLK_W] = word_q;
        assign valid_o[i] = vld_q;
    end

endmodule

// File: rtl/lane_stripe_tx.sv
module lane_stripe_tx
    import lane_stripe_pkg::*;
#(
    parameter int LANES  = 20,
    parameter int PERIOD = 16384,
    localparam int PW = ptr_width(LANES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [BLK_W-1:0]       in_data,
    output logic                   in_ready,
    output logic [LANES*BLK_W-1:0] lane_data,
    output logic [LANES-1:0]       lane_valid,
    output logic                   idle_drop
);

    logic          data_phase;
    logic          mark_fire;
    logic          accept;
    logic [PW-1:0] ptr;

    assign accept   = in_valid && data_phase;
    assign in_ready = data_phase;

    stripe_mark_timer #(.LANES(LANES), .PERIOD(PERIOD)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .accept_i     (accept),
        .data_phase_o (data_phase),
        .mark_fire_o  (mark_fire),
        .drop_o       (idle_drop)
    );

    stripe_rr_ptr #(.LANES(LANES)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (accept),
        .clear_i (mark_fire),
        .ptr_o   (ptr)
    );

    stripe_lane_regs #(.LANES(LANES)) u_lanes (
        .clk         (clk),
        .rst         (rst),
        .mark_fire_i (mark_fire),
        .accept_i    (accept),
        .ptr_i       (ptr),
        .blk_i       (in_data),
        .data_o      (lane_data),
        .valid_o     (lane_valid)
    );

    AST_ONE_LANE_PER_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> ($countones(lane_valid) == 1)); // R2
    AST_MARK_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |=> (&lane_valid)); // R3
    AST_QUIET_LANES: assert property (@(posedge clk) disable iff (rst)
        (!accept && !mark_fire) |=> (lane_valid == '0)); // R8
    AST_DROP_STALL: assert property (@(posedge clk) disable iff (rst)
        idle_drop |-> !in_ready); // R5

endmodule

// File: tb/lane_stripe_tx_bench.sv
module lane_stripe_tx_bench;
    localparam int L   = 4;
    localparam int P   = 3;
    localparam int LB  = 20;
    localparam int W   = 66;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic           in_valid = 1'b0;
    logic [W-1:0]   in_data  = '0;
    logic           in_ready;
    logic [L*W-1:0] lane_data;
    logic [L-1:0]   lane_valid;
    logic           idle_drop;

    logic            big_ready;
    logic [LB*W-1:0] big_data;
    logic [LB-1:0]   big_valid;
    logic            big_drop;

    lane_stripe_tx #(.LANES(L), .PERIOD(P)) u_lane_stripe_tx (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .lane_data(lane_data), .lane_valid(lane_valid),
        .idle_drop(idle_drop));

    lane_stripe_tx #(.LANES(LB), .PERIOD(2)) u_big (
        .clk(clk), .rst(rst), .in_valid(1'b0), .in_data('0),
        .in_ready(big_ready), .lane_data(big_data), .lane_valid(big_valid),
        .idle_drop(big_drop));

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] exp_q[$];
    bit done = 0;

    function automatic logic [W-1:0] exp_marker(input int n);
        logic [7:0] b;
        b = 8'(n);
        return {2'b10, 40'h0, ~b, b, 8'hA5};
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: push accepted blocks into the scoreboard queue.
    task automatic send(input int count);
        for (int k = 0; k < count; k++) begin
            logic [W-1:0] blk;
            blk = {2'b01, 64'h0123_4567_89AB_0000 ^ 64'(k * 7919)};
            if (k % 5 == 3) begin
                in_valid = 1'b0;  // R7: gap cycle
                @(posedge clk); @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = blk;
            while (!in_ready) begin @(posedge clk); @(negedge clk); end
            exp_q.push_back(blk);
            @(posedge clk); @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // Monitor
    bit expect_mark = 1;
    int seen = 0;
    int exp_lane = 0;
    int drop_run = 0;
    int groups = 0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (idle_drop) begin
                drop_run++;
                check(!in_ready, "R5 ready low while idle_drop", W'(in_ready), '0);
            end else if (drop_run != 0) begin
                check(drop_run == L, "R5 drop length", W'(drop_run), W'(L));
                drop_run = 0;
            end
            if (lane_valid != '0) begin
                if (expect_mark) begin
                    check(&lane_valid, "R3 all lanes carry marker", W'(lane_valid), W'({L{1'b1}}));
                    for (int i = 0; i < L; i++)
                        check(lane_data[i*W +: W] == exp_marker(i), "R4 marker content",
                              lane_data[i*W +: W], exp_marker(i));
                    expect_mark = 0;
                    exp_lane = 0;
                    groups++;
                end else begin
                    logic [W-1:0] e;
                    e = (exp_q.size() != 0) ? exp_q.pop_front() : 'x;
                    check(lane_valid == L'(1 << exp_lane), "R1 lane order",
                          W'(lane_valid), W'(1 << exp_lane));
                    check(lane_data[exp_lane*W +: W] === e, "R2 data passthrough",
                          lane_data[exp_lane*W +: W], e);
                    exp_lane = (exp_lane + 1) % L;
                    seen++;
                    if (seen == L * P) begin
                        seen = 0;
                        expect_mark = 1;
                    end
                end
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(lane_valid == '0, "R6 reset clears valid", W'(lane_valid), '0);
        check(big_valid == '0, "R6 reset clears valid (20 lanes)", W'(big_valid), '0);
        rst = 1'b0;
        @(negedge clk);
        // R6 / R9: markers right after reset on the 20-lane instance
        check(&big_valid, "R9 all 20 lanes marker", W'(big_valid), W'({LB{1'b1}}));
        for (int i = 0; i < LB; i++)
            check(big_data[i*W +: W] == exp_marker(i), "R9 marker id",
                  big_data[i*W +: W], exp_marker(i));
        begin
            int low = 1;
            while (!big_ready && low < 100) begin
                check(big_drop, "R5 drop during 20-lane group", W'(big_drop), 1);
                @(negedge clk); low++;
            end
            check(low == LB + 1 - 1 + 0 || low == LB, "R5 20-lane group length",
                  W'(low), W'(LB));
        end
        send(L * P * 3 + 5);
        repeat (L + 4) @(negedge clk);
        // R8: no stimulus -> outputs quiet
        check(lane_valid == '0, "R8 quiet lanes", W'(lane_valid), '0);
        check(exp_q.size() == 0, "R2 all blocks delivered", W'(exp_q.size()), '0);
        check(groups == 4, "R3 marker group count", W'(groups), W'(4));
        check(in_ready && !idle_drop, "R5 ready high outside groups",
              W'({in_ready, idle_drop}), W'(2'b10));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule